// File: doc/BRIEF.md
# Converter Link Power State Controller

This block sets the power state of a data converter that feeds a serial link. One control register holds two 2-bit mode fields, one for the link digital logic and one for the converter core, and two bits that let an external power-down pin push the link into standby. From the register and the pin, the controller drives enable lines for the link PLL, the serializer and the link clock gate. It also drives a reset for the link logic and run and standby indications for the converter core.

Link state changes go through a short sequencer. On entry to a low-power state, reset is applied while the clock still runs, and the clock is gated one cycle later. On the way out, the clock is ungated first and reset is released a fixed number of cycles after that. After a full power-down, the serializer also waits for the PLL to report that it is ready. The link target is the deeper of the state the register asks for and the state the pin forces, with power-down deeper than standby and standby deeper than normal.

Top module: `linkPwrCtl`

## Requirements
- R1: While `rstN` is low, `pllEn`, `serEn` and `linkClkEn` are 0, `linkRst` is 1, `coreRun` is 1 and `coreStandby` is 0. After `rstN` rises, the link runs the exit sequence of R10 from the power-down state.
- R2: A write with `wrEn`=1 updates the control register only when `wrAddr` equals `PWR_ADDR`. Writes to any other address leave every output unchanged. The register layout is: bits[1:0] core mode, bits[3:2] link mode, bit 4 pin-standby permit, bit 5 pin gate.
- R3: Link mode 01 selects power-down. Once settled, `pllEn`=0, `serEn`=0, `linkClkEn`=0 and `linkRst`=1.
- R4: Link mode 10 selects standby. Once settled, `pllEn`=1, `serEn`=0, `linkClkEn`=0 and `linkRst`=1.
- R5: Mode code 11 is reserved and behaves exactly like 00 (normal) in both fields.
- R6: Core mode drives the core outputs in the cycle after the write edge, independently of the link. 00 gives `coreRun`=1 and `coreStandby`=0. 01 gives both 0. 10 gives `coreRun`=0 and `coreStandby`=1.
- R7: The pin forces link standby only when `pdPin`=1, bit 4 = 1 and bit 5 = 1. If either bit is 0, the pin has no effect on the link.
- R8: The effective link target is the deeper of the register target and the pin target. A register power-down overrides a pin standby, and a pin standby holds the link down when the register asks for normal.
- R9: On entry, `linkRst` rises in the first cycle after the change is sampled, with `linkClkEn` still 1. `linkClkEn` falls in the next cycle.
- R10: On exit, `linkClkEn` (and `pllEn`) return to 1 in the first cycle, and `linkRst` falls `RST_HOLD` (default 2) cycles later.
- R11: After leaving power-down, `serEn` stays 0 until `pllReady` has been sampled high. After leaving standby, it asserts together with the release of `linkRst`.
- R12: `serEn` is 1 only while `linkClkEn`=1 and `linkRst`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 8 | Register write data |
| pdPin | input | 1 | External power-down pin, already synchronised |
| pllReady | input | 1 | PLL ready indication |
| pllEn | output | 1 | Link PLL enable |
| serEn | output | 1 | Serializer enable |
| linkClkEn | output | 1 | Link clock gate enable |
| linkRst | output | 1 | Link logic reset, active high |
| coreRun | output | 1 | Converter core in normal mode |
| coreStandby | output | 1 | Converter core in standby |

## Verification
The bench checks the order of reset and clock gating cycle by cycle on both entry and exit. A design that stopped the clock first, or released reset early, would miss an expected value in a specific cycle. It holds `pllReady` low through an exit from power-down to catch a serializer that switches on too early, and holds it low through an exit from standby to catch one that waits when it should not. It drives the pin with each gate bit cleared on its own, to catch a decoder that checks only one of them. It moves the register to power-down and back while the pin is holding standby, to catch a merge that lets the shallower request win or that drops the pin hold.

// File: rtl/linkPwrPkg.sv
package linkPwrPkg;

  localparam int CORE_LSB = 0;
  localparam int LINK_LSB = 2;
  localparam int PIN_STBY_BIT = 4;
  localparam int PIN_GATE_BIT = 5;
  localparam int CFG_W = 6;

  // ordered by depth so a plain compare picks the deeper request
  typedef enum logic [1:0] {
    LVL_RUN  = 2'd0,
    LVL_STBY = 2'd1,
    LVL_DOWN = 2'd2
  } pwrLvl_e;

  typedef enum logic [2:0] {
    SQ_RUN   = 3'd0,
    SQ_ENTER = 3'd1,
    SQ_LOW   = 3'd2,
    SQ_EXIT  = 3'd3
  } seqState_e;

  typedef struct packed {
    logic pllOn;
    logic serOn;
    logic clkOn;
    logic rstOn;
  } seqStrobe_t;

  function automatic pwrLvl_e lvlOf(input logic [1:0] code);
    case (code)
      2'b01:   return LVL_DOWN;
      2'b10:   return LVL_STBY;
      default: return LVL_RUN;
    endcase
  endfunction

  function automatic pwrLvl_e deeperOf(input pwrLvl_e a, input pwrLvl_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/linkPwrData.sv
module linkPwrData
  import linkPwrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 8'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pdPin,
  input  seqStrobe_t        strobe,
  output pwrLvl_e           tgtLvl,
  output logic              pllEn,
  output logic              serEn,
  output logic              linkClkEn,
  output logic              linkRst,
  output logic              coreRun,
  output logic              coreStandby
);

  logic [CFG_W-1:0] cfgReg;
  logic             hitWr;
  pwrLvl_e          regLvl;
  pwrLvl_e          pinLvl;
  pwrLvl_e          coreLvl;
  logic             pinArmed;

  assign hitWr = wrEn && (wrAddr == PWR_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (hitWr) begin
      cfgReg <= wrData[CFG_W-1:0];
    end
  end

  always_comb begin
    pinArmed = pdPin && cfgReg[PIN_STBY_BIT] && cfgReg[PIN_GATE_BIT];
    regLvl   = lvlOf(cfgReg[LINK_LSB +: 2]);
    pinLvl   = pinArmed ? LVL_STBY : LVL_RUN;
    tgtLvl   = deeperOf(regLvl, pinLvl);
    coreLvl  = lvlOf(cfgReg[CORE_LSB +: 2]);
  end

  assign pllEn       = strobe.pllOn;
  assign serEn       = strobe.serOn;
  assign linkClkEn   = strobe.clkOn;
  assign linkRst     = strobe.rstOn;
  assign coreRun     = (coreLvl == LVL_RUN);
  assign coreStandby = (coreLvl == LVL_STBY);

  // R3
  pll_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pllEn |-> (!linkClkEn && linkRst && !serEn));

  // R6
  core_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(coreRun && coreStandby));

endmodule

// File: rtl/linkPwrSeq.sv
module linkPwrSeq
  import linkPwrPkg::*;
#(
  parameter int RST_HOLD = 2,
  localparam int CNT_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  pwrLvl_e    tgtLvl,
  input  logic       pllReady,
  output seqStrobe_t strobe
);

  seqState_e  seqState;
  pwrLvl_e    lowLvl;
  logic [CNT_W-1:0] holdCnt;
  logic       pllWait;
  logic       inDown;

  assign inDown = (seqState == SQ_LOW) && (lowLvl == LVL_DOWN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState <= SQ_LOW;
      lowLvl   <= LVL_DOWN;
      holdCnt  <= '0;
    end else begin
      case (seqState)
        SQ_RUN: begin
          if (tgtLvl != LVL_RUN) begin
            seqState <= SQ_ENTER;
            lowLvl   <= tgtLvl;
          end
        end
        SQ_ENTER: begin
          seqState <= SQ_LOW;
          if (tgtLvl != LVL_RUN) lowLvl <= tgtLvl;
        end
        SQ_LOW: begin
          if (tgtLvl == LVL_RUN) begin
            seqState <= SQ_EXIT;
            holdCnt  <= '0;
          end else begin
            lowLvl <= tgtLvl;
          end
        end
        SQ_EXIT: begin
          if (holdCnt == CNT_W'(RST_HOLD - 1)) seqState <= SQ_RUN;
          else holdCnt <= holdCnt + 1'b1;
        end
        default: seqState <= SQ_LOW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pllWait <= 1'b1;
    else if (inDown) pllWait <= 1'b1;
    else if (pllReady) pllWait <= 1'b0;
  end

  always_comb begin
    strobe.clkOn = (seqState != SQ_LOW);
    strobe.rstOn = (seqState != SQ_RUN);
    strobe.pllOn = !inDown;
    strobe.serOn = (seqState == SQ_RUN) && !pllWait;
  end

  // R9
  rst_before_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.clkOn) |-> $past(strobe.rstOn));

  // R10
  gate_before_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.rstOn) |-> ($past(strobe.clkOn) && strobe.clkOn));

  // R12
  ser_needs_live_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.serOn |-> (strobe.clkOn && !strobe.rstOn));

  // R11
  ser_after_pll_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.pllOn) |-> !strobe.serOn);

endmodule

// File: rtl/linkPwrCtl.sv
module linkPwrCtl
  import linkPwrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 8'h08,
  parameter int RST_HOLD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              pdPin,
  input  logic              pllReady,
  output logic              pllEn,
  output logic              serEn,
  output logic              linkClkEn,
  output logic              linkRst,
  output logic              coreRun,
  output logic              coreStandby
);

  seqStrobe_t strobe;
  pwrLvl_e    tgtLvl;

  linkPwrData #(
    .ADDR_W(ADDR_W),
    .DATA_W(8),
    .PWR_ADDR(PWR_ADDR)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .pdPin(pdPin),
    .strobe(strobe),
    .tgtLvl(tgtLvl),
    .pllEn(pllEn),
    .serEn(serEn),
    .linkClkEn(linkClkEn),
    .linkRst(linkRst),
    .coreRun(coreRun),
    .coreStandby(coreStandby)
  );

  linkPwrSeq #(
    .RST_HOLD(RST_HOLD)
  ) uSeq (
    .clk(clk),
    .rstN(rstN),
    .tgtLvl(tgtLvl),
    .pllReady(pllReady),
    .strobe(strobe)
  );

endmodule

// File: tb/sim_linkPwrCtl.sv
`timescale 1ns/1ps
module sim_linkPwrCtl;

  localparam logic [7:0] PADDR = 8'h08;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic pdPin = 1'b0;
  logic pllReady = 1'b1;
  logic pllEn, serEn, linkClkEn, linkRst, coreRun, coreStandby;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  typedef struct {
    int         at;
    logic [5:0] v;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  linkPwrCtl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pdPin(pdPin), .pllReady(pllReady), .pllEn(pllEn), .serEn(serEn),
    .linkClkEn(linkClkEn), .linkRst(linkRst), .coreRun(coreRun),
    .coreStandby(coreStandby)
  );

  // {pll, ser, clk, rst, coreRun, coreStandby}
  function automatic logic [5:0] mk(bit p, bit s, bit c, bit r, bit cr, bit cs);
    return {p, s, c, r, cr, cs};
  endfunction

  task automatic push(input int at, input logic [5:0] v, input string tag);
    expItem_t it;
    it.at = at; it.v = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      expItem_t it;
      logic [5:0] act;
      it = expQ.pop_front();
      act = {pllEn, serEn, linkClkEn, linkRst, coreRun, coreStandby};
      nChecks++;
      if (act !== it.v || it.at != cyc) begin
        nFails++;
        $display("FAIL %s cycle %0d: actual=%b expected=%b", it.tag, it.at, act, it.v);
      end
    end
  end

  task automatic startWr(input logic [7:0] a, input logic [7:0] d, output int w);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    w = cyc + 1;
  endtask

  task automatic endWr();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPin(input bit v, output int p);
    @(negedge clk);
    pdPin = v;
    p = cyc + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [5:0] RUNV  = 6'b111010;
  localparam logic [5:0] ENTV  = 6'b101110;
  localparam logic [5:0] DOWNV = 6'b000110;
  localparam logic [5:0] STBV  = 6'b100110;

  initial begin
    int w;
    int p;
    // R1 reset state
    idle(2);
    push(cyc + 1, 6'b000110, "R1 reset");
    idle(2);
    @(negedge clk);
    rstN = 1'b1;
    w = cyc + 1;
    push(w,     ENTV, "R1 R10 boot clock ungated");
    push(w + 1, ENTV, "R10 boot reset held");
    push(w + 2, RUNV, "R10 R11 boot release");
    idle(6);

    // R3 R9 power-down entry
    startWr(PADDR, 8'h04, w);
    push(w,     RUNV,  "R9 unchanged at write");
    push(w + 1, ENTV,  "R9 reset before gate");
    push(w + 2, DOWNV, "R3 power-down");
    push(w + 4, DOWNV, "R3 power-down held");
    endWr();
    idle(5);
    pllReady = 1'b0;
    // R10 R11 exit waits for pll
    startWr(PADDR, 8'h00, w);
    push(w + 1, ENTV,         "R10 clock back");
    push(w + 2, ENTV,         "R10 reset still held");
    push(w + 3, 6'b101010,    "R11 ser waits pll");
    push(w + 5, 6'b101010,    "R11 ser still waiting");
    endWr();
    idle(6);
    @(negedge clk);
    pllReady = 1'b1;
    push(cyc + 1, RUNV, "R11 ser after pll ready");
    idle(4);

    // R4 standby, exit without pll wait
    startWr(PADDR, 8'h08, w);
    push(w + 1, ENTV, "R9 standby entry");
    push(w + 2, STBV, "R4 standby");
    endWr();
    idle(4);
    pllReady = 1'b0;
    startWr(PADDR, 8'h00, w);
    push(w + 3, RUNV, "R11 standby exit no wait");
    endWr();
    idle(5);
    pllReady = 1'b1;

    // R5 reserved codes
    startWr(PADDR, 8'h0F, w);
    push(w,     RUNV, "R5 reserved core");
    push(w + 2, RUNV, "R5 reserved link");
    endWr();
    idle(4);

    // R6 core modes
    startWr(PADDR, 8'h01, w);
    push(w, 6'b111000, "R6 core power-down");
    endWr();
    idle(3);
    startWr(PADDR, 8'h02, w);
    push(w, 6'b111001, "R6 core standby");
    push(w + 2, 6'b111001, "R6 link unaffected");
    endWr();
    idle(3);
    startWr(PADDR, 8'h00, w);
    push(w, RUNV, "R6 core normal");
    endWr();
    idle(3);

    // R2 other address ignored
    startWr(PADDR + 8'h01, 8'h06, w);
    push(w,     RUNV, "R2 foreign address core");
    push(w + 2, RUNV, "R2 foreign address link");
    endWr();
    idle(4);

    // R7 pin with both gate bits
    startWr(PADDR, 8'h30, w);
    endWr();
    idle(2);
    setPin(1'b1, p);
    push(p,     ENTV, "R7 pin entry");
    push(p + 1, STBV, "R7 pin standby");
    idle(4);
    setPin(1'b0, p);
    push(p + 2, RUNV, "R7 pin release");
    idle(5);
    // R7 only one gate bit set
    startWr(PADDR, 8'h10, w);
    endWr();
    idle(2);
    setPin(1'b1, p);
    push(p + 1, RUNV, "R7 bit5 clear ignores pin");
    idle(4);
    setPin(1'b0, p);
    startWr(PADDR, 8'h20, w);
    endWr();
    idle(2);
    setPin(1'b1, p);
    push(p + 1, RUNV, "R7 bit4 clear ignores pin");
    idle(4);
    setPin(1'b0, p);
    idle(2);

    // R8 deeper request wins
    startWr(PADDR, 8'h30, w);
    endWr();
    idle(2);
    setPin(1'b1, p);
    push(p + 1, STBV, "R8 pin standby");
    idle(4);
    startWr(PADDR, 8'h34, w);
    push(w + 1, DOWNV, "R8 register power-down deeper");
    endWr();
    idle(4);
    startWr(PADDR, 8'h30, w);
    push(w + 1, STBV, "R8 pin holds standby");
    push(w + 3, STBV, "R8 pin still holds");
    endWr();
    idle(4);
    setPin(1'b0, p);
    push(p + 2, RUNV, "R8 release to normal");
    idle(6);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      nFails++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule